// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Generator

This block produces the vertical timing of a display pipe from a line strobe. In fixed mode every frame has the same programmed total. In variable mode, blanking is stretched: a frame lasts at least the flipline length and at most the vmax length. Within that range, a push request from the host ends blanking early. Blanking leaves through an exit stretch of guardband lines. The one-cycle register latch pulse fires when the exit starts. Timing registers are double-buffered, and their working copies load on that pulse.

Software programs the line counts through a small write port and reads them back one cycle after presenting an address. The vmin, vmax, flipline and vertical total registers hold the line count minus one. A status bit shows whether variable mode is live. That bit changes only at a frame wrap, so software polls it after turning the mode off.

Top module: `vrr_vtg`

## Requirements
- R1: Address 0 (vmin), 1 (vmax), 2 (flipline), 5 (vertical total) and 6 (vblank start line) each read back the value last written. Address 3 (control) reads back as: bit0 mode enable, bit1 flipline enable, bit2 ignore-max-shift, bits 15:8 guardband. Address 4 (push) reads back as: bit0 push enable, bit1 pending send. Read data appears one clock after the address.
- R2: In fixed mode a frame lasts vertical-total register + 1 line strobes. vcount runs from 0, and vblank is high from the vblank start line to the end of the frame.
- R3: In fixed mode the latch pulse fires while vcount equals the vblank start line, once per frame.
- R4: In variable mode with no push, the exit starts at line vmax+1−guardband (register values plus one), the latch pulse fires there, and the frame lasts vmax register + 1 lines.
- R5: A push written before the earliest exit line (flipline register + 1 − guardband) is held until that line; the frame then lasts exactly flipline register + 1 lines.
- R6: A push written while vcount is v, with v inside the window, starts the exit on line v: the latch pulse fires at line v and the frame lasts v + guardband lines.
- R7: Writing push with bits 1:0 = 11 sets the send bit, which reads 1 while pending and clears when the exit it causes begins.
- R8: The generator falls back to the fixed total when the latched vmin register is not below the latched vmax register, or when flipline enable is clear, even with the mode enabled.
- R9: A change of the mode enable bit takes effect at the next frame wrap; the live bit (address 7 bit0 and the vrr_live pin) changes at that same wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| line_stb | input | 1 | One pulse per scan line |
| vcount | output | 12 | Current line within the frame |
| vblank | output | 1 | Vertical blanking active |
| frame_start | output | 1 | One-cycle pulse after a frame wrap |
| latch_pulse | output | 1 | One-cycle pulse when working registers load |
| vrr_live | output | 1 | Variable mode live status |

## Verification
The bench goes after the edges of the exit window. A push landing before the earliest exit line must be held rather than dropped or acted on at once. A design that acts on it at once would produce frames shorter than the flipline, and one that drops it would run every frame to vmax. With no push, a design that misses the vmax boundary would run past the maximum length. Random guardband values and push lines are measured frame by frame against a computed length and latch line. Off-by-one errors in the minus-one encoding or in the exit stretch show up as frames one line long or short. The bench also checks that the live bit does not flip in the middle of a frame, and that the fallback conditions really return the fixed total.

// File: rtl/vrr_pkg.sv
package vrr_pkg;
  localparam int LINE_W = 12;
  localparam int DATA_W = 16;
  localparam int GB_W   = 8;
  localparam int GB_LSB = 8;

  typedef enum logic [2:0] {
    A_VMIN = 3'd0, A_VMAX = 3'd1, A_FLIP = 3'd2, A_CTRL = 3'd3,
    A_PUSH = 3'd4, A_VTOT = 3'd5, A_VBS  = 3'd6, A_STAT = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [LINE_W-1:0] vmin;
    logic [LINE_W-1:0] vmax;
    logic [LINE_W-1:0] flip;
    logic [LINE_W-1:0] vtot;
    logic [LINE_W-1:0] vbs;
    logic [GB_W-1:0]   gb;
    logic              flip_en;
  } timing_t;
endpackage

// File: rtl/vrr_regfile.sv
module vrr_regfile import vrr_pkg::*; #(
  parameter int DEF_VTOT = 19,
  parameter int DEF_VBS  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              latch,
  input  logic              send_clr,
  input  logic              live,
  output timing_t           act,
  output logic              ctrl_en,
  output logic              push_pend
);
  timing_t shd;
  logic ign_max, push_en, send;
  logic [DATA_W-1:0] rd_mux;
  logic push_wr;

  assign push_wr   = wr && (addr == A_PUSH);
  assign push_pend = push_en && send;

  always_ff @(posedge clk) begin
    if (rst) begin
      shd      <= '0;
      shd.vtot <= LINE_W'(DEF_VTOT);
      shd.vbs  <= LINE_W'(DEF_VBS);
      ctrl_en  <= 1'b0;
      ign_max  <= 1'b0;
      push_en  <= 1'b0;
    end else if (wr) begin
      case (reg_addr_e'(addr))
        A_VMIN: shd.vmin <= wdata[LINE_W-1:0];
        A_VMAX: shd.vmax <= wdata[LINE_W-1:0];
        A_FLIP: shd.flip <= wdata[LINE_W-1:0];
        A_VTOT: shd.vtot <= wdata[LINE_W-1:0];
        A_VBS:  shd.vbs  <= wdata[LINE_W-1:0];
        A_CTRL: begin
          ctrl_en     <= wdata[0];
          shd.flip_en <= wdata[1];
          ign_max     <= wdata[2];
          shd.gb      <= wdata[GB_LSB +: GB_W];
        end
        A_PUSH: push_en <= wdata[0];
        default: ;
      endcase
    end
  end

  // pending send: a fresh write wins over the automatic clear
  always_ff @(posedge clk) begin
    if (rst)           send <= 1'b0;
    else if (push_wr)  send <= wdata[0] & wdata[1];
    else if (send_clr) send <= 1'b0;
  end

  // working copy loads on the latch pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= '0;
      act.vtot <= LINE_W'(DEF_VTOT);
      act.vbs  <= LINE_W'(DEF_VBS);
    end else if (latch) begin
      act <= shd;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr_e'(addr))
      A_VMIN: rd_mux[LINE_W-1:0] = shd.vmin;
      A_VMAX: rd_mux[LINE_W-1:0] = shd.vmax;
      A_FLIP: rd_mux[LINE_W-1:0] = shd.flip;
      A_VTOT: rd_mux[LINE_W-1:0] = shd.vtot;
      A_VBS:  rd_mux[LINE_W-1:0] = shd.vbs;
      A_CTRL: begin
        rd_mux[0] = ctrl_en;
        rd_mux[1] = shd.flip_en;
        rd_mux[2] = ign_max;
        rd_mux[GB_LSB +: GB_W] = shd.gb;
      end
      A_PUSH: rd_mux[1:0] = {send, push_en};
      A_STAT: rd_mux[0] = live;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R7
  send_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(send_clr && !push_wr) |-> !send);
endmodule

// File: rtl/vrr_window.sv
module vrr_window import vrr_pkg::*; (
  input  timing_t           act,
  input  logic              active,
  input  logic [LINE_W-1:0] vc,
  input  logic              pend,
  input  logic              exiting,
  input  logic [LINE_W:0]   exit_end,
  output logic              start_exit,
  output logic [LINE_W:0]   end_line
);
  logic [LINE_W:0] gb_eff, flip_l, vmax_l, e_min, e_max_raw, e_max, vc_x;

  always_comb begin
    vc_x      = {1'b0, vc};
    gb_eff    = (act.gb == '0) ? (LINE_W+1)'(1) : (LINE_W+1)'(act.gb);
    flip_l    = {1'b0, act.flip} + 1'b1;
    vmax_l    = {1'b0, act.vmax} + 1'b1;
    e_min     = (flip_l > gb_eff) ? flip_l - gb_eff : '0;
    e_max_raw = (vmax_l > gb_eff) ? vmax_l - gb_eff : '0;
    e_max     = (e_max_raw < e_min) ? e_min : e_max_raw;
    start_exit = active && !exiting &&
                 ((pend && vc_x >= e_min) || vc_x >= e_max);
    end_line  = exiting ? exit_end : vc_x + gb_eff - 1'b1;
  end
endmodule

// File: rtl/vrr_vtg.sv
module vrr_vtg import vrr_pkg::*; #(
  parameter int DEF_VTOT = 19,
  parameter int DEF_VBS  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              line_stb,
  output logic [LINE_W-1:0] vcount,
  output logic              vblank,
  output logic              frame_start,
  output logic              latch_pulse,
  output logic              vrr_live
);
  timing_t act;
  logic ctrl_en, push_pend, vrr_mode, start_exit, latch, wrap, exiting_q;
  logic [LINE_W:0]   end_line, exit_end_q;
  logic [LINE_W-1:0] nxt;

  vrr_regfile #(.DEF_VTOT(DEF_VTOT), .DEF_VBS(DEF_VBS)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .latch(latch), .send_clr(start_exit), .live(vrr_live),
    .act(act), .ctrl_en(ctrl_en), .push_pend(push_pend)
  );

  assign vrr_mode = vrr_live && act.flip_en && (act.vmin < act.vmax);

  vrr_window u_win (
    .act(act), .active(vrr_mode), .vc(vcount), .pend(push_pend),
    .exiting(exiting_q), .exit_end(exit_end_q),
    .start_exit(start_exit), .end_line(end_line)
  );

  always_comb begin
    if (vrr_mode) wrap = line_stb && (exiting_q || start_exit) && ({1'b0, vcount} >= end_line);
    else          wrap = line_stb && (vcount >= act.vtot);
    nxt   = wrap ? '0 : vcount + 1'b1;
    latch = vrr_mode ? start_exit : (line_stb && nxt == act.vbs);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vcount      <= '0;
      vblank      <= 1'b0;
      frame_start <= 1'b0;
      latch_pulse <= 1'b0;
      vrr_live    <= 1'b0;
      exiting_q   <= 1'b0;
      exit_end_q  <= '0;
    end else begin
      frame_start <= wrap;
      latch_pulse <= latch;
      if (start_exit) begin
        exiting_q  <= 1'b1;
        exit_end_q <= end_line;
      end
      if (line_stb) begin
        vcount <= nxt;
        vblank <= (nxt >= act.vbs) && (act.vbs != '0 || !wrap);
      end
      if (wrap) begin
        exiting_q <= 1'b0;
        vrr_live  <= ctrl_en;
      end
    end
  end

  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> $past(line_stb));
  // R3
  latch_once_chk: assert property (@(posedge clk) disable iff (rst)
    latch_pulse |=> !latch_pulse);
  // R5
  min_len_chk: assert property (@(posedge clk) disable iff (rst)
    (vrr_mode && wrap) |-> vcount >= act.flip);
  // R9
  live_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(vrr_live) |-> frame_start);
endmodule

// File: tb/vrr_vtg_test.sv
module vrr_vtg_test;
  localparam int CLK_PERIOD = 10;

  logic clk, rst, reg_wr, line_stb;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [11:0] vcount;
  logic vblank, frame_start, latch_pulse, vrr_live;

  int checks = 0, errors = 0;
  int frame_cnt = 0, stb_cnt = 0, len_q = 0, lat_line = 0;

  vrr_vtg uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_stb(line_stb),
    .vcount(vcount), .vblank(vblank), .frame_start(frame_start),
    .latch_pulse(latch_pulse), .vrr_live(vrr_live)
  );

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    int sc;
    sc = 0;
    line_stb = 0;
    forever begin
      @(negedge clk);
      sc = sc + 1;
      line_stb = (sc % 4 == 0);
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      stb_cnt <= 0;
    end else begin
      if (frame_start) begin
        len_q     <= stb_cnt;
        stb_cnt   <= line_stb ? 1 : 0;
        frame_cnt <= frame_cnt + 1;
      end else if (line_stb) begin
        stb_cnt <= stb_cnt + 1;
      end
      if (latch_pulse) lat_line <= int'(vcount);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input int a, output int d);
    @(negedge clk);
    reg_addr = 3'(a);
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  task automatic wait_frames(input int n);
    for (int i = 0; i < n; i++) begin
      int f;
      f = frame_cnt;
      do @(negedge clk); while (frame_cnt == f);
    end
  endtask

  task automatic wait_line(input int v);
    do @(negedge clk); while (int'(vcount) != v);
  endtask

  function automatic int ctrl_word(input int en, input int fen, input int gb);
    return (gb << 8) | 4 | (fen << 1) | en;
  endfunction

  // frame length for a push written at line v (v < 0: no push)
  function automatic int exp_len(input int v, input int flip_l, input int vmax_l, input int gb);
    int emin, emax, e;
    emin = flip_l - gb;
    emax = vmax_l - gb;
    if (v < 0) e = emax;
    else e = (v < emin) ? emin : ((v > emax) ? emax : v);
    return e + gb;
  endfunction

  function automatic int exp_lat(input int v, input int flip_l, input int vmax_l, input int gb);
    return exp_len(v, flip_l, vmax_l, gb) - gb;
  endfunction

  initial begin
    int d, gb, v;
    void'($urandom(32'd1234));
    rst = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R2 reset vcount", int'(vcount), 0);
    check("R2 reset vblank", int'(vblank), 0);
    check("R9 reset live", int'(vrr_live), 0);

    wr_reg(5, 19); wr_reg(6, 14);
    wr_reg(0, 19); wr_reg(1, 39); wr_reg(2, 20);
    wr_reg(3, ctrl_word(0, 1, 6));
    wr_reg(4, 1);
    rd_reg(0, d); check("R1 vmin", d, 19);
    rd_reg(1, d); check("R1 vmax", d, 39);
    rd_reg(2, d); check("R1 flipline", d, 20);
    rd_reg(3, d); check("R1 control", d, ctrl_word(0, 1, 6));
    rd_reg(4, d); check("R1 push", d, 1);
    rd_reg(5, d); check("R1 vtotal", d, 19);
    rd_reg(6, d); check("R1 vblank start", d, 14);

    wait_frames(2);
    wait_line(13); check("R2 vblank before start", int'(vblank), 0);
    wait_line(14); check("R2 vblank at start", int'(vblank), 1);
    wait_frames(1);
    check("R2 fixed length", len_q, 20);
    check("R3 fixed latch line", lat_line, 14);

    wr_reg(3, ctrl_word(1, 1, 6));
    check("R9 live held mid-frame", int'(vrr_live), 0);
    wait_frames(1);
    check("R9 live after wrap", int'(vrr_live), 1);
    rd_reg(7, d); check("R9 status readback", d & 1, 1);

    wait_frames(1);
    check("R4 no push length", len_q, 40);
    check("R4 no push latch line", lat_line, 34);

    wait_line(3);
    wr_reg(4, 3);
    rd_reg(4, d); check("R7 send pending", d, 3);
    wait_frames(1);
    check("R5 early push length", len_q, 21);
    check("R5 early push latch line", lat_line, 15);
    rd_reg(4, d); check("R7 send cleared", d, 1);

    wait_line(25);
    wr_reg(4, 3);
    wait_frames(1);
    check("R6 window push length", len_q, 31);
    check("R6 window push latch line", lat_line, 25);

    for (int it = 0; it < 16; it++) begin
      gb = 1 + int'($urandom % 8);
      wr_reg(3, ctrl_word(1, 1, gb));
      wait_frames(2);
      if ($urandom % 4 == 0) begin
        v = -1;
      end else begin
        v = 1 + int'($urandom % (39 - gb));
        wait_line(v);
        wr_reg(4, 3);
      end
      wait_frames(1);
      check("R6 random length", len_q, exp_len(v, 21, 40, gb));
      check("R6 random latch line", lat_line, exp_lat(v, 21, 40, gb));
    end

    wr_reg(3, ctrl_word(1, 1, 6));
    wr_reg(0, 39);
    wait_frames(3);
    check("R8 vmin>=vmax fallback", len_q, 20);
    wr_reg(0, 19);
    wait_frames(2);
    wr_reg(3, ctrl_word(1, 0, 6));
    wait_frames(3);
    check("R8 flipline disabled fallback", len_q, 20);
    wr_reg(3, ctrl_word(1, 1, 6));
    wait_frames(3);
    check("R4 mode restored", len_q, 40);

    wr_reg(3, ctrl_word(0, 1, 6));
    check("R9 live held after disable", int'(vrr_live), 1);
    wait_frames(1);
    check("R9 live cleared at wrap", int'(vrr_live), 0);
    wait_frames(1);
    check("R2 fixed after disable", len_q, 20);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule